// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

After reset the DRAM pins sit deselected with the clock enable low. A one-cycle start strobe begins the power-up sequence. The block raises the clock enable and holds every command back for a minimum settle interval. It then issues a precharge-all and three extended mode register loads, for bank selects 2, 3 and 1 in that order, and pulses a done flag.

The precharge-all never stands alone. It always sits directly ahead of the load to extended mode register 2. The same address, with bank select 2 and address bit 10 high, is held on the bus from the precharge through that load. The DLL-enable and reduced-drive-strength bits for extended mode register 1 are sampled when the start strobe is accepted. The settle interval is a clock count derived from the clock period parameter and the minimum settle time. The precharge and load-mode recovery gaps are parameters.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, cke is 0, cs_n is 1, ras_n/cas_n/we_n are 1, ba and addr are 0 and done is 0.
- R2: A start seen in the idle state raises cke after that clock edge. cke then stays 1 until reset. cs_n is the inverse of cke, so commands and NOPs are selected while cke is high.
- R3: No command other than NOP appears until cke has been high for CKE_CYCLES cycles, where CKE_CYCLES = ceil(CKE_MIN_PS / CLK_PERIOD_PS). With the default 4000 ps period and 400000 ps minimum this is 100. The precharge appears in exactly cycle CKE_CYCLES after the accepting edge.
- R4: Precharge-all is encoded ras_n=0, cas_n=1, we_n=0 with addr[10]=1 and ba=2'b10. It is followed by T_RP NOP cycles and then, directly, the load to extended mode register 2. It is never issued in any other position.
- R5: The first load-mode (ras_n=0, cas_n=0, we_n=0) uses ba=2'b10 and addr=14'h0400. ba and addr keep these values from the precharge cycle through the end of this load's gap.
- R6: After T_MRD NOP cycles the second load-mode uses ba=2'b11 and addr=0, with no precharge before it.
- R7: After T_MRD more NOP cycles the third load-mode uses ba=2'b01. addr[0] is the dll_en value and addr[1] is the drv_reduced value, both as sampled at the accepting start edge. All other address bits are 0.
- R8: A NOP is ras_n=cas_n=we_n=1 with cs_n=0. Each load-mode is followed by T_MRD NOP cycles that keep that command's ba and addr.
- R9: done is 1 for exactly the one cycle after the last gap. ba and addr are 0 in that cycle. The block then returns to idle, where a new start runs the whole sequence again.
- R10: A start while the sequence is busy, including the done cycle, is ignored. Changes on dll_en and drv_reduced after the accepting edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| dll_en | input | 1 | DLL-enable value for extended mode register 1 |
| drv_reduced | input | 1 | Reduced-drive-strength value for extended mode register 1 |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 14 | Row/mode address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every cycle of every run is compared with a full expected pin vector, computed from the cycle offset since the accepting edge. An off-by-one settle or gap counter therefore shows up as a command shifted by one cycle. Some runs hold start high for the whole sequence, and one raises it only in the done cycle. A design that re-accepts start would restart the settle wait or skip idle. The mode bits toggle randomly while the sequence is busy, so a design that reads them live instead of capturing them gives a wrong extended mode register 1 address. A precharge that drops bit 10 before the following load would show up as a miscompared address in the gap or load cycles.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CKE_WAIT,
    ST_PRE,
    ST_PRE_GAP,
    ST_LM2,
    ST_LM2_GAP,
    ST_LM3,
    ST_LM3_GAP,
    ST_LM1,
    ST_LM1_GAP,
    ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr_cmd_t CMD_PRE = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam ddr_cmd_t CMD_LM  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam logic [1:0] BA_EMR1 = 2'b01;
  localparam logic [1:0] BA_EMR2 = 2'b10;
  localparam logic [1:0] BA_EMR3 = 2'b11;

  localparam int PRE_ALL_BIT = 10;

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int CKE_CYCLES = 100,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dll_en,
  input  logic       drv_reduced,
  output seq_state_e state,
  output logic       cke_on,
  output logic       dll_cap,
  output logic       drv_cap
);

  localparam int GAP_MAX  = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int LOAD_MAX = (CKE_CYCLES > GAP_MAX) ? CKE_CYCLES : GAP_MAX;
  localparam int CNT_W    = (LOAD_MAX > 1) ? $clog2(LOAD_MAX) : 1;

  localparam logic [CNT_W-1:0] LD_CKE = CNT_W'(CKE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_CKE_WAIT;
        tmr_load = 1'b1;
        tmr_val  = LD_CKE;
      end
      ST_CKE_WAIT: if (tmr_done) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_PRE_GAP;
        tmr_load = 1'b1;
        tmr_val  = LD_RP;
      end
      ST_PRE_GAP: if (tmr_done) state_d = ST_LM2;
      ST_LM2: begin
        state_d  = ST_LM2_GAP;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
      end
      ST_LM2_GAP: if (tmr_done) state_d = ST_LM3;
      ST_LM3: begin
        state_d  = ST_LM3_GAP;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
      end
      ST_LM3_GAP: if (tmr_done) state_d = ST_LM1;
      ST_LM1: begin
        state_d  = ST_LM1_GAP;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
      end
      ST_LM1_GAP: if (tmr_done) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  ddr2_init_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_on  <= 1'b0;
      dll_cap <= 1'b0;
      drv_cap <= 1'b0;
    end else if (accept) begin
      cke_on  <= 1'b1;
      dll_cap <= dll_en;
      drv_cap <= drv_reduced;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ddr2_init_drive.sv
module ddr2_init_drive
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  seq_state_e        state,
  input  logic              cke_on,
  input  logic              dll_cap,
  input  logic              drv_cap,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  ddr_cmd_t          cmd;
  logic [ADDR_W-1:0] a_emr2, a_emr1;

  always_comb begin
    a_emr2              = '0;
    a_emr2[PRE_ALL_BIT] = 1'b1;
    a_emr1              = '0;
    a_emr1[0]           = dll_cap;
    a_emr1[1]           = drv_cap;
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = 2'b00;
    addr = '0;
    done = 1'b0;
    unique case (state)
      ST_PRE: begin
        cmd = CMD_PRE; ba = BA_EMR2; addr = a_emr2;
      end
      ST_PRE_GAP, ST_LM2_GAP: begin
        ba = BA_EMR2; addr = a_emr2;
      end
      ST_LM2: begin
        cmd = CMD_LM; ba = BA_EMR2; addr = a_emr2;
      end
      ST_LM3:     begin cmd = CMD_LM; ba = BA_EMR3; end
      ST_LM3_GAP: ba = BA_EMR3;
      ST_LM1: begin
        cmd = CMD_LM; ba = BA_EMR1; addr = a_emr1;
      end
      ST_LM1_GAP: begin
        ba = BA_EMR1; addr = a_emr1;
      end
      ST_FIN:  done = 1'b1;
      default: ;
    endcase
  end

  assign cs_n  = ~cke_on;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int CKE_MIN_PS    = 400000,
  parameter int T_RP          = 3,
  parameter int T_MRD         = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dll_en,
  input  logic        drv_reduced,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [13:0] addr,
  output logic        done
);

  localparam int CKE_CYCLES = (CKE_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

  seq_state_e state;
  logic       cke_on, dll_cap, drv_cap;

  ddr2_init_ctrl #(
    .CKE_CYCLES (CKE_CYCLES),
    .T_RP       (T_RP),
    .T_MRD      (T_MRD)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dll_en      (dll_en),
    .drv_reduced (drv_reduced),
    .state       (state),
    .cke_on      (cke_on),
    .dll_cap     (dll_cap),
    .drv_cap     (drv_cap)
  );

  ddr2_init_drive #(.ADDR_W(14)) i_drive (
    .state   (state),
    .cke_on  (cke_on),
    .dll_cap (dll_cap),
    .drv_cap (drv_cap),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .addr    (addr),
    .done    (done)
  );

  assign cke = cke_on;

endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk #(
  parameter int CKE_CYCLES = 100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [13:0] addr,
  input logic        done
);

  logic [31:0] cke_cnt;
  logic        pre_pending;
  logic [1:0]  last_lm_ba;
  logic        is_cmd, is_pre, is_lm;

  assign is_cmd = !cs_n && !ras_n;
  assign is_pre = is_cmd && cas_n && !we_n;
  assign is_lm  = is_cmd && !cas_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_cnt     <= '0;
      pre_pending <= 1'b0;
      last_lm_ba  <= 2'b00;
    end else begin
      if (!cke)                         cke_cnt <= '0;
      else if (cke_cnt < CKE_CYCLES)    cke_cnt <= cke_cnt + 1;
      if (is_pre)                       pre_pending <= 1'b1;
      else if (is_lm)                   pre_pending <= 1'b0;
      if (is_lm)                        last_lm_ba <= ba;
    end
  end

  // R2
  p_cke_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R3
  p_cke_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (cke_cnt >= CKE_CYCLES));

  // R4
  p_pre_a10_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[10]);

  // R4
  p_pre_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_pending |-> (!is_pre && !done));

  // R5
  p_pre_fuses_emr2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_pending && is_lm) |-> (ba == 2'b10 && addr == 14'h0400));

  // R6
  p_emr3_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lm && ba == 2'b11) |-> (!pre_pending && last_lm_ba == 2'b10 && addr == 14'h0000));

  // R7
  p_emr1_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lm && ba == 2'b01) |-> (last_lm_ba == 2'b11 && addr[13:2] == 12'h000));

  // R8
  p_cmd_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |=> !is_cmd);

  // R9
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind ddr2_init_seq ddr2_init_chk #(.CKE_CYCLES(CKE_CYCLES)) i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cke   (cke),
  .cs_n  (cs_n),
  .ras_n (ras_n),
  .cas_n (cas_n),
  .we_n  (we_n),
  .ba    (ba),
  .addr  (addr),
  .done  (done)
);

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;

  localparam int PERIOD_PS = 4000;
  localparam int SETTLE_PS = 400000;
  localparam int NRP       = 3;
  localparam int NMRD      = 2;
  localparam int NC        = (SETTLE_PS + PERIOD_PS - 1) / PERIOD_PS;
  localparam int J_END     = NC + NRP + 4 + 3 * NMRD;

  logic        clk = 1'b0;
  logic        rst_n, start, dll_en, drv_reduced;
  logic        cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]  ba;
  logic [13:0] addr;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  ddr2_init_seq #(
    .CLK_PERIOD_PS (PERIOD_PS),
    .CKE_MIN_PS    (SETTLE_PS),
    .T_RP          (NRP),
    .T_MRD         (NMRD)
  ) i_ddr2_init_seq (
    .clk (clk), .rst_n (rst_n), .start (start), .dll_en (dll_en),
    .drv_reduced (drv_reduced), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .done (done)
  );

  // {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done}
  function automatic logic [21:0] pack(logic k, logic [2:0] c, logic [1:0] b,
                                       logic [13:0] a, logic d);
    return {k, ~k, c, b, a, d};
  endfunction

  function automatic logic [21:0] exp_vec(int j, logic d, logic r);
    int p0 = NC;
    int l2 = NC + NRP + 1;
    int l3 = l2 + NMRD + 1;
    int l1 = l3 + NMRD + 1;
    if (j < p0)        return pack(1, 3'b111, 2'b00, 14'h0000, 0);
    if (j == p0)       return pack(1, 3'b010, 2'b10, 14'h0400, 0);
    if (j < l2)        return pack(1, 3'b111, 2'b10, 14'h0400, 0);
    if (j == l2)       return pack(1, 3'b000, 2'b10, 14'h0400, 0);
    if (j < l3)        return pack(1, 3'b111, 2'b10, 14'h0400, 0);
    if (j == l3)       return pack(1, 3'b000, 2'b11, 14'h0000, 0);
    if (j < l1)        return pack(1, 3'b111, 2'b11, 14'h0000, 0);
    if (j == l1)       return pack(1, 3'b000, 2'b01, {12'h000, r, d}, 0);
    if (j < J_END)     return pack(1, 3'b111, 2'b01, {12'h000, r, d}, 0);
    if (j == J_END)    return pack(1, 3'b111, 2'b00, 14'h0000, 1);
    return pack(1, 3'b111, 2'b00, 14'h0000, 0);
  endfunction

  function automatic string tag(int j);
    if (j == 0)               return "R2";
    if (j < NC)               return "R3";
    if (j <= NC + NRP)        return "R4";
    if (j == NC + NRP + 1)    return "R5";
    if (j == NC + NRP + 2 + NMRD)     return "R6";
    if (j == NC + NRP + 3 + 2 * NMRD) return "R7";
    if (j < J_END)            return "R8";
    if (j == J_END)           return "R9";
    return "R10";
  endfunction

  task automatic check(logic [21:0] exp, string req);
    logic [21:0] got;
    got = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done};
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // mode 0: start held high while busy; 1: start only in the done cycle; else random
  task automatic run_seq(int mode);
    logic d, r;
    d = 1'($urandom % 2);
    r = 1'($urandom % 2);
    start = 1'b1; dll_en = d; drv_reduced = r;
    @(negedge clk);
    for (int j = 0; j <= J_END + 1; j++) begin
      check(exp_vec(j, d, r), tag(j));
      if (j <= J_END) begin
        case (mode)
          0:       start = 1'b1;
          1:       start = (j == J_END);
          default: start = ($urandom % 4 == 0);
        endcase
        dll_en      = 1'($urandom % 2);
        drv_reduced = 1'($urandom % 2);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; dll_en = 1'b1; drv_reduced = 1'b1;
    repeat (3) @(negedge clk);
    check(pack(0, 3'b111, 2'b00, 14'h0000, 0), "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pack(0, 3'b111, 2'b00, 14'h0000, 0), "R1");
    run_seq(0);
    run_seq(1);
    for (int n = 0; n < 14; n++) begin
      for (int g = 0; g < int'($urandom % 4); g++) begin
        check(pack(1, 3'b111, 2'b00, 14'h0000, 0), "R10");
        dll_en = 1'($urandom % 2);
        @(negedge clk);
      end
      run_seq(2);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule